// File: doc/BRIEF.md
# Doorbell Interrupt Register Block

This block holds the small register window of a shared-memory device that links several compute nodes. Software sees four 32-bit word registers: an interrupt enable mask, an interrupt status word that empties itself when software reads it, the node's own position number (read-only), and a doorbell. Writing the doorbell asks the fabric to signal one event vector on one peer node. The block checks the destination peer and the vector against a live table of how many vectors each peer has registered. It emits a one-cycle strobe only when both checks pass.

Events that arrive for the local node are handled in one of two modes. In legacy mode, any event forces the status word to the value 1, and a level interrupt follows the masked status. In message-signalled mode, each event becomes a per-vector notify pulse. If that vector is masked, the event becomes a pending-set pulse instead. Nothing happens when message-signalled interrupts are globally disabled.

Top module: `shm_doorbell_regs`

## Requirements
- R1: After reset the mask and status registers read 0, and `irq_level`, `bell_valid`, `vec_notify`, `vec_pend_set` and `rd_valid` are all low.
- R2: A write to word offset 0 loads the mask, and a write to offset 4 loads the status, with all 32 data bits. Address bits [1:0] are ignored on writes, so a write to address 5 loads the status.
- R3: A read of offset 4 returns the status value held before the access and leaves the status at 0 afterwards.
- R4: A read of offset 8 returns `own_pos` in bits [15:0] with zeros above. Writes to offset 8 change nothing.
- R5: A doorbell write (offset 12) takes the destination from data bits [31:16] and the vector from bits [7:0]. Bits [15:8] have no effect. An accepted write raises `bell_valid` with `bell_dest` and `bell_vec` for exactly one cycle, on the clock edge that captures the write.
- R6: A doorbell whose destination is not below `peer_count`, or not below the table size NPEERS, produces no strobe.
- R7: A doorbell whose vector is not below the destination's entry in `peer_vec_cnt` produces no strobe. Entry p occupies bits [p*CNT_W +: CNT_W].
- R8: Reads of any address other than exactly 0, 4 or 8 return 0. This includes offset 12 and addresses with nonzero bits [1:0]. Writes to word offsets other than 0, 1, 2 and 3 have no effect.
- R9: With `msi_mode` low, any asserted bit of `evt` sets the status to exactly 1, replacing the old value. This takes priority over a status write or a status read-clear in the same cycle.
- R10: With `msi_mode` high, the status is never touched by events. When `msix_en` is high, an event on vector v pulses `vec_notify[v]` if `vec_mask[v]` is 0, or pulses `vec_pend_set[v]` if `vec_mask[v]` is 1, one cycle later. When `msix_en` is low, neither output pulses.
- R11: `irq_level` is high exactly when the bitwise AND of status and mask is nonzero.
- R12: Every read request is answered by `rd_valid` high for one cycle on the next clock edge, with `rd_data` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address in the register window |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| own_pos | input | 16 | Local node position number |
| peer_count | input | 16 | Number of peers currently known |
| peer_vec_cnt | input | NPEERS*CNT_W | Registered vector count per peer |
| msi_mode | input | 1 | 0 = legacy status mode, 1 = per-vector message mode |
| msix_en | input | 1 | Global enable for per-vector messages |
| vec_mask | input | NVEC | Per-vector message mask |
| evt | input | NVEC | Local event pulses, one per vector |
| bell_valid | output | 1 | Accepted doorbell strobe |
| bell_dest | output | 16 | Doorbell destination peer |
| bell_vec | output | 8 | Doorbell vector |
| vec_notify | output | NVEC | Per-vector notify pulse |
| vec_pend_set | output | NVEC | Per-vector pending-set pulse |
| irq_level | output | 1 | Legacy level interrupt |

## Verification
A stale or corrupted status word shows up on `irq_level` in the same cycle it is stored. It also shows up in the data of the next status read, one cycle after the request. A read-clear that misses, or an event that loses to a clear, therefore appears within two cycles. A wrong range check on the doorbell appears as a missing or extra `bell_valid` on the edge after the write. Mis-routed vectors appear as a pulse on the wrong bit of `vec_notify` or `vec_pend_set` one cycle after the event. A cycle-accurate model compares all of these outputs on every clock.

// File: rtl/shm_db_pkg.sv
package shm_db_pkg;

  localparam int ADDR_W = 8;

  localparam logic [5:0] WORD_MASK = 6'd0;
  localparam logic [5:0] WORD_STAT = 6'd1;
  localparam logic [5:0] WORD_POS  = 6'd2;
  localparam logic [5:0] WORD_BELL = 6'd3;

  function automatic logic [15:0] bell_dest_of(input logic [31:0] d);
    return d[31:16];
  endfunction

  function automatic logic [7:0] bell_vec_of(input logic [31:0] d);
    return d[7:0];
  endfunction

  // Reads decode the full byte address; only aligned words are mapped.
  function automatic logic [31:0] read_mux(input logic [ADDR_W-1:0] a,
                                           input logic [31:0] mask_q,
                                           input logic [31:0] stat_q,
                                           input logic [15:0] pos);
    logic [31:0] r;
    r = '0;
    if (a == {WORD_MASK, 2'b00}) r = mask_q;
    else if (a == {WORD_STAT, 2'b00}) r = stat_q;
    else if (a == {WORD_POS, 2'b00}) r = {16'h0000, pos};
    return r;
  endfunction

endpackage

// File: rtl/shm_bell_gate.sv
module shm_bell_gate #(
  parameter int NPEERS = 4,
  parameter int CNT_W  = 8
) (
  input  logic                      bell_wr,
  input  logic [31:0]               wdata,
  input  logic [15:0]               peer_count,
  input  logic [NPEERS*CNT_W-1:0]   vec_cnt,
  output logic                      accept,
  output logic [15:0]               dest,
  output logic [7:0]                vec
);
  import shm_db_pkg::*;

  localparam int IDX_W = (NPEERS > 1) ? $clog2(NPEERS) : 1;

  logic [CNT_W-1:0] cnt_arr [NPEERS];
  logic             dest_ok;
  logic [CNT_W-1:0] sel_cnt;

  for (genvar p = 0; p < NPEERS; p++) begin : g_peer
    assign cnt_arr[p] = vec_cnt[p*CNT_W +: CNT_W];
  end

  always_comb begin
    dest    = bell_dest_of(wdata);
    vec     = bell_vec_of(wdata);
    dest_ok = (32'(dest) < 32'(peer_count)) && (32'(dest) < 32'(NPEERS));
    sel_cnt = dest_ok ? cnt_arr[dest[IDX_W-1:0]] : '0;
    accept  = bell_wr && dest_ok && (32'(vec) < 32'(sel_cnt));
  end

endmodule

// File: rtl/shm_evt_route.sv
module shm_evt_route #(
  parameter int NVEC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            msi_mode,
  input  logic            msix_en,
  input  logic [NVEC-1:0] vec_mask,
  input  logic [NVEC-1:0] evt,
  output logic            leg_hit,
  output logic [NVEC-1:0] notify,
  output logic [NVEC-1:0] pend
);

  logic [NVEC-1:0] ntf_d, pnd_d;

  assign leg_hit = !msi_mode && (|evt);

  for (genvar v = 0; v < NVEC; v++) begin : g_vec
    assign ntf_d[v] = msi_mode & msix_en & evt[v] & ~vec_mask[v];
    assign pnd_d[v] = msi_mode & msix_en & evt[v] &  vec_mask[v];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      notify <= '0;
      pend   <= '0;
    end else begin
      notify <= ntf_d;
      pend   <= pnd_d;
    end
  end

  AST_NTF_PND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (notify & pend) == '0);  // R10
  AST_MSI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((|notify) || (|pend)) |-> $past(msi_mode && msix_en));  // R10

endmodule

// File: rtl/shm_doorbell_regs.sv
module shm_doorbell_regs
  import shm_db_pkg::*;
#(
  parameter int NPEERS = 4,
  parameter int NVEC   = 4,
  parameter int CNT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [31:0]              req_wdata,
  output logic                     rd_valid,
  output logic [31:0]              rd_data,
  input  logic [15:0]              own_pos,
  input  logic [15:0]              peer_count,
  input  logic [NPEERS*CNT_W-1:0]  peer_vec_cnt,
  input  logic                     msi_mode,
  input  logic                     msix_en,
  input  logic [NVEC-1:0]          vec_mask,
  input  logic [NVEC-1:0]          evt,
  output logic                     bell_valid,
  output logic [15:0]              bell_dest,
  output logic [7:0]               bell_vec,
  output logic [NVEC-1:0]          vec_notify,
  output logic [NVEC-1:0]          vec_pend_set,
  output logic                     irq_level
);

  logic [31:0] mask_q, stat_q, stat_d;
  logic        rd_req, wr_req, stat_rd;
  logic [5:0]  wr_word;
  logic        bell_ok, leg_hit;
  logic [15:0] gate_dest;
  logic [7:0]  gate_vec;

  assign rd_req  = req_valid && !req_write;
  assign wr_req  = req_valid &&  req_write;
  assign wr_word = req_addr[ADDR_W-1:2];
  assign stat_rd = rd_req && (req_addr == {WORD_STAT, 2'b00});

  shm_bell_gate #(.NPEERS(NPEERS), .CNT_W(CNT_W)) u_gate (
    .bell_wr    (wr_req && (wr_word == WORD_BELL)),
    .wdata      (req_wdata),
    .peer_count (peer_count),
    .vec_cnt    (peer_vec_cnt),
    .accept     (bell_ok),
    .dest       (gate_dest),
    .vec        (gate_vec)
  );

  shm_evt_route #(.NVEC(NVEC)) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .msi_mode (msi_mode),
    .msix_en  (msix_en),
    .vec_mask (vec_mask),
    .evt      (evt),
    .leg_hit  (leg_hit),
    .notify   (vec_notify),
    .pend     (vec_pend_set)
  );

  // Status priority: local event > read-clear > bus write > hold.
  always_comb begin
    stat_d = stat_q;
    if (wr_req && (wr_word == WORD_STAT)) stat_d = req_wdata;
    if (stat_rd)                          stat_d = '0;
    if (leg_hit)                          stat_d = 32'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '0;
      stat_q     <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      bell_valid <= 1'b0;
      bell_dest  <= '0;
      bell_vec   <= '0;
    end else begin
      stat_q     <= stat_d;
      rd_valid   <= rd_req;
      bell_valid <= bell_ok;
      if (wr_req && (wr_word == WORD_MASK)) mask_q <= req_wdata;
      if (rd_req) rd_data <= read_mux(req_addr, mask_q, stat_q, own_pos);
      if (bell_ok) begin
        bell_dest <= gate_dest;
        bell_vec  <= gate_vec;
      end
    end
  end

  assign irq_level = |(stat_q & mask_q);

  AST_STAT_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !leg_hit) |=> (stat_q == 32'd0));  // R3
  AST_LEG_EVT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    leg_hit |=> (stat_q == 32'd1));  // R9
  AST_BELL_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bell_valid |-> $past(wr_req && (wr_word == WORD_BELL)));  // R5
  AST_BELL_DEST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bell_valid |-> (32'(bell_dest) < 32'($past(peer_count))));  // R6

endmodule

// File: tb/shm_doorbell_regs_tb_top.sv
`timescale 1ns/1ps
module shm_doorbell_regs_tb_top;
  localparam int NP = 4;
  localparam int NV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [15:0] own_pos = 16'h0002;
  logic [15:0] peer_count = 16'd3;
  logic [31:0] peer_vec_cnt;
  logic        msi_mode = 1'b0, msix_en = 1'b0;
  logic [3:0]  vec_mask = '0, evt = '0;
  logic        bell_valid;
  logic [15:0] bell_dest;
  logic [7:0]  bell_vec;
  logic [3:0]  vec_notify, vec_pend_set;
  logic        irq_level;

  int tb_cnt [NP] = '{4, 1, 3, 0};
  assign peer_vec_cnt = {8'(tb_cnt[3]), 8'(tb_cnt[2]), 8'(tb_cnt[1]), 8'(tb_cnt[0])};

  always #2 clk = ~clk;

  shm_doorbell_regs #(.NPEERS(NP), .NVEC(NV), .CNT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .own_pos(own_pos), .peer_count(peer_count), .peer_vec_cnt(peer_vec_cnt),
    .msi_mode(msi_mode), .msix_en(msix_en), .vec_mask(vec_mask), .evt(evt),
    .bell_valid(bell_valid), .bell_dest(bell_dest), .bell_vec(bell_vec),
    .vec_notify(vec_notify), .vec_pend_set(vec_pend_set), .irq_level(irq_level)
  );

  int n_chk = 0, n_bad = 0;
  bit cmp_on = 0, done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, updated on each rising edge.
  logic [31:0] m_mask, m_sts, m_rdd;
  logic        m_rdv, m_dbv;
  int          m_dbd, m_dbvec;
  logic [3:0]  m_ntf, m_pnd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask = 0; m_sts = 0; m_rdd = 0; m_rdv = 0; m_dbv = 0;
      m_dbd = 0; m_dbvec = 0; m_ntf = 0; m_pnd = 0;
    end else begin
      m_rdv = 0; m_dbv = 0; m_ntf = 0; m_pnd = 0;
      if (req_valid && !req_write) begin
        m_rdv = 1;
        if (req_addr == 0) m_rdd = m_mask;
        else if (req_addr == 4) begin m_rdd = m_sts; m_sts = 0; end
        else if (req_addr == 8) m_rdd = {16'h0, own_pos};
        else m_rdd = 0;
      end
      if (req_valid && req_write) begin
        int a, d, v;
        a = int'(req_addr) & 'hFC;
        if (a == 0) m_mask = req_wdata;
        else if (a == 4) m_sts = req_wdata;
        else if (a == 12) begin
          d = int'(req_wdata >> 16);
          v = int'(req_wdata & 32'hFF);
          if (d < int'(peer_count) && d < NP && v < tb_cnt[d]) begin
            m_dbv = 1; m_dbd = d; m_dbvec = v;
          end
        end
      end
      if (!msi_mode && evt != 0) m_sts = 1;
      if (msi_mode && msix_en)
        for (int v = 0; v < NV; v++)
          if (evt[v]) begin
            if (vec_mask[v]) m_pnd[v] = 1; else m_ntf[v] = 1;
          end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check("R12 rd_valid", rd_valid, m_rdv);
      if (m_rdv) check("R3 R8 rd_data", rd_data, m_rdd);
      check("R5 bell_valid", bell_valid, m_dbv);
      if (m_dbv) begin
        check("R5 bell_dest", bell_dest, m_dbd);
        check("R5 bell_vec", bell_vec, m_dbvec);
      end
      check("R10 vec_notify", vec_notify, m_ntf);
      check("R10 vec_pend_set", vec_pend_set, m_pnd);
      check("R11 irq_level", irq_level, |(m_mask & m_sts));
    end
  end

  // Drive one access cycle from a falling edge; return at the next falling edge.
  task automatic cyc(input logic v, input logic w, input logic [7:0] a,
                     input logic [31:0] d, input logic [3:0] e);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; evt = e;
    @(negedge clk);
    req_valid = 0; req_write = 0; evt = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1, 1, a, d, 4'b0);
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] exp, input string tag);
    cyc(1, 0, a, 32'h0, 4'b0);
    check(tag, rd_data, exp);
  endtask

  task automatic bell_exp(input logic [31:0] d, input logic ok, input int dst,
                          input int vv, input string tag);
    wr(8'd12, d);
    check(tag, bell_valid, ok);
    if (ok) begin
      check(tag, bell_dest, dst);
      check(tag, bell_vec, vv);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog act=0 exp=1");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1; cmp_on = 1;
    // R1 reset state
    check("R1 irq_level", irq_level, 0);
    check("R1 bell_valid", bell_valid, 0);
    check("R1 notify", vec_notify, 0);
    check("R1 rd_valid", rd_valid, 0);
    rd_exp(8'd0, 32'h0, "R1 mask reset");
    rd_exp(8'd4, 32'h0, "R1 status reset");
    // R2 writes and address low bits ignored
    wr(8'd0, 32'hFFFF_0001);
    rd_exp(8'd0, 32'hFFFF_0001, "R2 mask readback");
    wr(8'd5, 32'h0000_0006);
    check("R11 irq low", irq_level, 0);
    wr(8'd0, 32'h0000_0002);
    check("R11 irq high", irq_level, 1);
    // R3 read clears
    rd_exp(8'd4, 32'h6, "R3 status value");
    check("R11 irq after clear", irq_level, 0);
    rd_exp(8'd4, 32'h0, "R3 status cleared");
    // R4 position read-only
    rd_exp(8'd8, 32'h0000_0002, "R4 position");
    wr(8'd8, 32'h1234_5678);
    rd_exp(8'd8, 32'h0000_0002, "R4 position write ignored");
    // R8 unmapped
    rd_exp(8'd12, 32'h0, "R8 doorbell read");
    rd_exp(8'd1, 32'h0, "R8 unaligned read");
    rd_exp(8'h40, 32'h0, "R8 high read");
    wr(8'h40, 32'hFFFF_FFFF);
    rd_exp(8'd0, 32'h2, "R8 mask untouched");
    rd_exp(8'd4, 32'h0, "R8 status untouched");
    // R5 R6 R7 doorbell
    bell_exp({16'd2, 8'hFF, 8'd2}, 1, 2, 2, "R5 bell accepted");
    cyc(0, 0, 8'd0, 32'h0, 4'b0);
    check("R5 single cycle", bell_valid, 0);
    bell_exp({16'd0, 8'h01, 8'd3}, 1, 0, 3, "R5 bits 15:8 ignored");
    bell_exp({16'd1, 8'h00, 8'd1}, 0, 0, 0, "R7 vector over count");
    bell_exp({16'd3, 8'h00, 8'd0}, 0, 0, 0, "R6 dest over peer_count");
    peer_count = 16'd9;
    bell_exp({16'd3, 8'h00, 8'd0}, 0, 0, 0, "R7 zero vectors");
    bell_exp({16'd5, 8'h00, 8'd0}, 0, 0, 0, "R6 dest over table");
    // R9 legacy events
    wr(8'd0, 32'h1);
    cyc(0, 0, 8'd0, 32'h0, 4'b0100);
    check("R9 event raises irq", irq_level, 1);
    wr(8'd4, 32'hF0);
    cyc(0, 0, 8'd0, 32'h0, 4'b0001);
    rd_exp(8'd4, 32'h1, "R9 overwrite not OR");
    wr(8'd4, 32'h30);
    cyc(1, 0, 8'd4, 32'h0, 4'b0001);
    check("R3 read returns old", rd_data, 32'h30);
    rd_exp(8'd4, 32'h1, "R9 event beats clear");
    cyc(1, 1, 8'd4, 32'h55, 4'b1000);
    rd_exp(8'd4, 32'h1, "R9 event beats write");
    // R10 message mode
    msi_mode = 1;
    cyc(0, 0, 8'd0, 32'h0, 4'b1111);
    check("R10 disabled notify", vec_notify, 0);
    check("R10 disabled pend", vec_pend_set, 0);
    rd_exp(8'd4, 32'h0, "R10 status untouched");
    msix_en = 1; vec_mask = 4'b0010;
    cyc(0, 0, 8'd0, 32'h0, 4'b0011);
    check("R10 notify", vec_notify, 4'b0001);
    check("R10 pending", vec_pend_set, 4'b0010);
    cyc(0, 0, 8'd0, 32'h0, 4'b0);
    check("R10 pulse ends", vec_notify, 0);
    rd_exp(8'd4, 32'h0, "R10 status still zero");
    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule